// File: doc/BRIEF.md
# Pipelined Burst Address Sequencer

This block is the master-side engine that turns one local command into a burst of transfers on a pipelined system bus. The bus has a separate address phase and data phase, and the two overlap. The local side gives a start address, a burst code, a transfer size, a direction and, for open-ended incrementing bursts, a length. The engine then places one address and control phase on the bus for each beat. It marks each phase as the first beat of a burst, a following beat, a pause, or no transfer.

The bus can stretch any phase by holding its ready input low, and the engine freezes its outputs for as long as that lasts. The local side can ask for pause cycles between beats. Wrapping bursts fold their addresses inside an aligned block of bytes-per-beat times beat count. Write data is registered into the data phase that follows each accepted address phase, and read data is registered when its data phase completes. An error response stops the burst early. The end of every burst is reported with a one-cycle pulse.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous reset, `bus_trans` is 00 (no transfer), `cmd_ready` is 1, and `done` and `rd_valid` are 0. Whenever `cmd_ready` is high, `bus_trans` is 00.
- R2: A command accepted with `cmd_size` greater than 2 (wider than the 32-bit data bus) raises `cmd_reject` for exactly the next cycle, and `bus_trans` stays 00.
- R3: The cycle after a valid command is accepted, `bus_trans` is 10 (first beat) and `bus_addr` equals the command address. `bus_burst`, `bus_size` and `bus_write` copy the command fields.
- R4: Every beat after the first is shown as 11 (following beat). In an incrementing burst, each beat address is the previous beat address plus 2^`cmd_size` bytes.
- R5: In a wrapping burst (burst codes 010, 100, 110 for 4, 8 and 16 beats), the next address is the previous address plus 2^size, folded back to the start of the aligned block of 2^size times beats bytes.
- R6: Beat count by burst code: 000 gives one beat, 001 gives `cmd_len`+1 beats, 010/011 give 4, 100/101 give 8, and 110/111 give 16. A beat counts when `bus_ready` is 1 at the edge while `bus_trans` is 10 or 11.
- R7: While `bus_ready` is 0 during a beat, the address, transfer type, burst, size and direction outputs hold steady into the next cycle.
- R8: When `loc_busy` is 1 at the edge that accepts a beat or a pause, the next phase is 01 (pause), with the address of the next beat still to come. A pause does not count as a beat, and the address does not advance past it.
- R9: During the data phase of a write beat, `bus_wdata` holds the `wr_data` value sampled at the edge that accepted that beat's address phase.
- R10: For a read beat, the edge where its data phase completes with `bus_ready` 1 and `bus_err` 0 loads `rd_data` from `bus_rdata` and raises `rd_valid` for one cycle.
- R11: `bus_err` high with `bus_ready` 1 during an open data phase ends the burst. The next phase is 00, any address phase accepted at that same edge is dropped, and `done` and `err_flag` pulse together one cycle later.
- R12: When the data phase of the last beat completes without error, `done` pulses for one cycle with `err_flag` 0, and `bus_trans` is 00 at that point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; everything acts on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle with no open data phase; a command is taken when valid and ready are both high |
| cmd_addr | input | ADDR_W | Start address |
| cmd_burst | input | 3 | Burst code (see R6) |
| cmd_size | input | 3 | Bytes per beat = 2^size; 0 to 2 are legal |
| cmd_write | input | 1 | 1 write, 0 read |
| cmd_len | input | LEN_W | Beats minus one for the open-ended incrementing burst |
| cmd_reject | output | 1 | One-cycle pulse when a command had an illegal size |
| loc_busy | input | 1 | Local side asks for a pause before the next beat |
| wr_data | input | DATA_W | Write data for the beat being accepted |
| beat_take | output | 1 | A beat address phase is accepted at this edge |
| rd_data | output | DATA_W | Captured read data |
| rd_valid | output | 1 | `rd_data` is new this cycle |
| done | output | 1 | One-cycle pulse when the burst has ended |
| err_flag | output | 1 | With `done`: the burst ended on an error response |
| bus_addr | output | ADDR_W | Bus address phase |
| bus_trans | output | 2 | 00 none, 01 pause, 10 first beat, 11 following beat |
| bus_burst | output | 3 | Burst code of the running burst |
| bus_size | output | 3 | Size code of the running burst |
| bus_write | output | 1 | Direction of the running burst |
| bus_wdata | output | DATA_W | Write data for the open data phase |
| bus_ready | input | 1 | Bus completes the current phases at this edge |
| bus_err | input | 1 | Error response for the open data phase |
| bus_rdata | input | DATA_W | Read data for the open data phase |

## Verification
The assertions assume that the bus raises `bus_err` only while a data phase is open and only together with `bus_ready`. They also assume that no incrementing burst crosses the bus's address-region limit, since the engine does not check this. The bench's slave model follows its own record of outstanding beats and drives an error only onto a beat it holds open, always with ready high. Stall and pause patterns come from per-cycle masks, so every wait state and pause falls inside a running burst.

// File: rtl/bas_pkg.sv
package bas_pkg;
  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  localparam logic [2:0] BR_SINGLE = 3'd0;
  localparam logic [2:0] BR_INCR   = 3'd1;
  localparam logic [2:0] BR_WRAP4  = 3'd2;
  localparam logic [2:0] BR_INCR4  = 3'd3;
  localparam logic [2:0] BR_WRAP8  = 3'd4;
  localparam logic [2:0] BR_INCR8  = 3'd5;
  localparam logic [2:0] BR_WRAP16 = 3'd6;
  localparam logic [2:0] BR_INCR16 = 3'd7;
endpackage

// File: rtl/bas_cmd_decode.sv
module bas_cmd_decode import bas_pkg::*; #(
  parameter int LEN_W    = 8,
  parameter int CNT_W    = 9,
  parameter int MAX_SIZE = 2
) (
  input  logic [2:0]       burst,
  input  logic [2:0]       size,
  input  logic [LEN_W-1:0] len,
  output logic             size_ok,
  output logic [CNT_W-1:0] beats,
  output logic             wrap,
  output logic [2:0]       wrap_lg
);
  always_comb begin
    size_ok = (size <= 3'(MAX_SIZE));
    wrap    = (burst == BR_WRAP4) || (burst == BR_WRAP8) || (burst == BR_WRAP16);
    unique case (burst[2:1])
      2'b01:   wrap_lg = 3'd2;
      2'b10:   wrap_lg = 3'd3;
      2'b11:   wrap_lg = 3'd4;
      default: wrap_lg = 3'd0;
    endcase
    unique case (burst)
      BR_SINGLE:           beats = CNT_W'(1);
      BR_INCR:             beats = CNT_W'(len) + CNT_W'(1);
      BR_WRAP4, BR_INCR4:  beats = CNT_W'(4);
      BR_WRAP8, BR_INCR8:  beats = CNT_W'(8);
      default:             beats = CNT_W'(16);
    endcase
  end
endmodule

// File: rtl/bas_addr_step.sv
module bas_addr_step #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        size,
  input  logic              wrap,
  input  logic [2:0]        wrap_lg,
  output logic [ADDR_W-1:0] nxt
);
  logic [ADDR_W-1:0] step;
  logic [ADDR_W-1:0] inc;
  logic [ADDR_W-1:0] mask;
  logic [3:0]        blk_lg;

  always_comb begin
    step   = ADDR_W'(1) << size;
    inc    = addr + step;
    blk_lg = {1'b0, size} + {1'b0, wrap_lg};
    mask   = (ADDR_W'(1) << blk_lg) - ADDR_W'(1);
    if (wrap) nxt = (addr & ~mask) | (inc & mask);
    else      nxt = inc;
  end
endmodule

// File: rtl/bas_data_stage.sv
module bas_data_stage #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_ready,
  input  logic              bus_err,
  input  logic              acc,
  input  logic              acc_write,
  input  logic              acc_last,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              dph_valid,
  output logic              err_now,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              fin,
  output logic              fin_err
);
  logic dph_write;
  logic dph_last;

  assign err_now = dph_valid && bus_ready && bus_err;

  always_ff @(posedge clk) begin
    if (rst) begin
      dph_valid <= 1'b0;
      dph_write <= 1'b0;
      dph_last  <= 1'b0;
      bus_wdata <= '0;
      rd_data   <= '0;
      rd_valid  <= 1'b0;
      fin       <= 1'b0;
      fin_err   <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      fin      <= 1'b0;
      fin_err  <= 1'b0;
      if (bus_ready) begin
        if (dph_valid) begin
          if (bus_err) begin
            fin     <= 1'b1;
            fin_err <= 1'b1;
          end else begin
            if (!dph_write) begin
              rd_data  <= bus_rdata;
              rd_valid <= 1'b1;
            end
            if (dph_last) fin <= 1'b1;
          end
        end
        if (acc && !err_now) begin
          dph_valid <= 1'b1;
          dph_write <= acc_write;
          dph_last  <= acc_last;
          if (acc_write) bus_wdata <= wr_data;
        end else begin
          dph_valid <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq import bas_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [2:0]        cmd_burst,
  input  logic [2:0]        cmd_size,
  input  logic              cmd_write,
  input  logic [LEN_W-1:0]  cmd_len,
  output logic              cmd_reject,
  input  logic              loc_busy,
  input  logic [DATA_W-1:0] wr_data,
  output logic              beat_take,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done,
  output logic              err_flag,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [1:0]        bus_trans,
  output logic [2:0]        bus_burst,
  output logic [2:0]        bus_size,
  output logic              bus_write,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_ready,
  input  logic              bus_err,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int MAX_SIZE = $clog2(DATA_W / 8);
  localparam int CNT_W    = (LEN_W + 1 > 5) ? LEN_W + 1 : 5;

  logic              run_q;
  logic [CNT_W-1:0]  rem_q;
  logic              wrap_q;
  logic [2:0]        wlg_q;
  logic              size_ok;
  logic [CNT_W-1:0]  dec_beats;
  logic              dec_wrap;
  logic [2:0]        dec_wlg;
  logic [ADDR_W-1:0] nxt_addr;
  logic              dph_valid;
  logic              err_now;
  logic              acc_last;
  logic [1:0]        follow_tr;

  bas_cmd_decode #(.LEN_W(LEN_W), .CNT_W(CNT_W), .MAX_SIZE(MAX_SIZE)) u_dec (
    .burst  (cmd_burst),
    .size   (cmd_size),
    .len    (cmd_len),
    .size_ok(size_ok),
    .beats  (dec_beats),
    .wrap   (dec_wrap),
    .wrap_lg(dec_wlg)
  );

  bas_addr_step #(.ADDR_W(ADDR_W)) u_step (
    .addr   (bus_addr),
    .size   (bus_size),
    .wrap   (wrap_q),
    .wrap_lg(wlg_q),
    .nxt    (nxt_addr)
  );

  assign cmd_ready = !run_q && !dph_valid;
  assign beat_take = bus_ready && bus_trans[1];
  assign acc_last  = (rem_q == CNT_W'(1));
  assign follow_tr = loc_busy ? TR_BUSY : TR_SEQ;

  bas_data_stage #(.DATA_W(DATA_W)) u_data (
    .clk      (clk),
    .rst      (rst),
    .bus_ready(bus_ready),
    .bus_err  (bus_err),
    .acc      (beat_take),
    .acc_write(bus_write),
    .acc_last (acc_last),
    .wr_data  (wr_data),
    .bus_rdata(bus_rdata),
    .bus_wdata(bus_wdata),
    .dph_valid(dph_valid),
    .err_now  (err_now),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .fin      (done),
    .fin_err  (err_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      rem_q      <= '0;
      wrap_q     <= 1'b0;
      wlg_q      <= '0;
      bus_addr   <= '0;
      bus_trans  <= TR_IDLE;
      bus_burst  <= '0;
      bus_size   <= '0;
      bus_write  <= 1'b0;
      cmd_reject <= 1'b0;
    end else begin
      cmd_reject <= 1'b0;
      if (!run_q) begin
        if (cmd_valid && cmd_ready) begin
          if (!size_ok) begin
            cmd_reject <= 1'b1;
          end else begin
            run_q     <= 1'b1;
            rem_q     <= dec_beats;
            wrap_q    <= dec_wrap;
            wlg_q     <= dec_wlg;
            bus_addr  <= cmd_addr;
            bus_trans <= TR_NSEQ;
            bus_burst <= cmd_burst;
            bus_size  <= cmd_size;
            bus_write <= cmd_write;
          end
        end
      end else if (bus_ready) begin
        if (err_now) begin
          run_q     <= 1'b0;
          bus_trans <= TR_IDLE;
        end else if (beat_take) begin
          if (acc_last) begin
            run_q     <= 1'b0;
            bus_trans <= TR_IDLE;
          end else begin
            rem_q     <= rem_q - CNT_W'(1);
            bus_addr  <= nxt_addr;
            bus_trans <= follow_tr;
          end
        end else begin
          bus_trans <= follow_tr;
        end
      end
    end
  end
endmodule

// File: rtl/bas_chk.sv
module bas_chk #(
  parameter int ADDR_W   = 32,
  parameter int MAX_SIZE = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [2:0]        cmd_size,
  input logic              cmd_reject,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [1:0]        bus_trans,
  input logic [2:0]        bus_burst,
  input logic [2:0]        bus_size,
  input logic              bus_write,
  input logic              bus_ready,
  input logic              bus_err,
  input logic              dph_valid,
  input logic              done,
  input logic              err_flag
);
  // R1
  idle_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (bus_trans == 2'b00));

  // R2
  reject_size_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_size > 3'(MAX_SIZE)) |=> (cmd_reject && bus_trans == 2'b00));

  // R3
  first_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready && cmd_size <= 3'(MAX_SIZE)) |=>
      (bus_trans == 2'b10 && bus_addr == $past(cmd_addr)));

  // R7
  wait_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!bus_ready && bus_trans[1]) |=>
      ($stable(bus_addr) && $stable(bus_trans) && $stable(bus_burst) &&
       $stable(bus_size) && $stable(bus_write)));

  // R8
  pause_addr_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && bus_trans == 2'b01 && !(dph_valid && bus_err)) |=>
      (bus_trans[0] && bus_addr == $past(bus_addr)));

  // R11
  err_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_ready && dph_valid && bus_err) |=> (bus_trans == 2'b00 && done && err_flag));

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

bind burst_addr_seq bas_chk #(.ADDR_W(ADDR_W), .MAX_SIZE(MAX_SIZE)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_addr  (cmd_addr),
  .cmd_size  (cmd_size),
  .cmd_reject(cmd_reject),
  .bus_addr  (bus_addr),
  .bus_trans (bus_trans),
  .bus_burst (bus_burst),
  .bus_size  (bus_size),
  .bus_write (bus_write),
  .bus_ready (bus_ready),
  .bus_err   (bus_err),
  .dph_valid (dph_valid),
  .done      (done),
  .err_flag  (err_flag)
);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  import bas_pkg::*;

  logic        clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst;
  logic        cmd_valid;
  logic        cmd_ready;
  logic [31:0] cmd_addr;
  logic [2:0]  cmd_burst;
  logic [2:0]  cmd_size;
  logic        cmd_write;
  logic [7:0]  cmd_len;
  logic        cmd_reject;
  logic        loc_busy;
  logic [31:0] wr_data;
  logic        beat_take;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        done;
  logic        err_flag;
  logic [31:0] bus_addr;
  logic [1:0]  bus_trans;
  logic [2:0]  bus_burst;
  logic [2:0]  bus_size;
  logic        bus_write;
  logic [31:0] bus_wdata;
  logic        bus_ready;
  logic        bus_err;
  logic [31:0] bus_rdata;

  burst_addr_seq u_dut (
    .clk(clk), .rst(rst),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr),
    .cmd_burst(cmd_burst), .cmd_size(cmd_size), .cmd_write(cmd_write),
    .cmd_len(cmd_len), .cmd_reject(cmd_reject), .loc_busy(loc_busy),
    .wr_data(wr_data), .beat_take(beat_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .err_flag(err_flag),
    .bus_addr(bus_addr), .bus_trans(bus_trans), .bus_burst(bus_burst),
    .bus_size(bus_size), .bus_write(bus_write), .bus_wdata(bus_wdata),
    .bus_ready(bus_ready), .bus_err(bus_err), .bus_rdata(bus_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] wpat(input int i);
    return 32'hA000_0000 + 32'(i) * 32'h0000_0101;
  endfunction

  function automatic logic [31:0] rpat(input int i);
    return 32'h5000_0000 ^ (32'(i) * 32'h0011_0003);
  endfunction

  function automatic bit is_wrap(input logic [2:0] br);
    return (br == BR_WRAP4) || (br == BR_WRAP8) || (br == BR_WRAP16);
  endfunction

  function automatic int exp_beats(input logic [2:0] br, input logic [7:0] ln);
    case (br)
      BR_SINGLE:          return 1;
      BR_INCR:            return int'(ln) + 1;
      BR_WRAP4, BR_INCR4: return 4;
      BR_WRAP8, BR_INCR8: return 8;
      default:            return 16;
    endcase
  endfunction

  function automatic logic [31:0] enext(input logic [31:0] a, input logic [2:0] sz,
                                        input logic [2:0] br, input int beats);
    logic [31:0] step;
    logic [31:0] blk;
    logic [31:0] base;
    step = 32'd1 << sz;
    if (!is_wrap(br)) return a + step;
    blk  = step * 32'(beats);
    base = a - (a % blk);
    return base + ((a - base + step) % blk);
  endfunction

  task automatic run_burst(input logic [31:0] a, input logic [2:0] br, input logic [2:0] sz,
                           input bit wr, input logic [7:0] ln, input logic [31:0] stall,
                           input logic [31:0] busy, input int err_beat);
    int          beats;
    int          exp_cnt;
    logic [31:0] ea;
    int          acc;
    bit          pv;
    int          pidx;
    bit          prd;
    int          ridx;
    bit          hold;
    logic [31:0] ha;
    logic [1:0]  ht;
    bit          seen_done;
    int          busy_seen;
    beats     = exp_beats(br, ln);
    exp_cnt   = (err_beat >= 0 && err_beat + 2 < beats) ? err_beat + 2 : beats;
    ea        = a;
    acc       = 0;
    pv        = 0;
    pidx      = 0;
    prd       = 0;
    ridx      = 0;
    hold      = 0;
    ha        = '0;
    ht        = '0;
    seen_done = 0;
    busy_seen = 0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1", 32'(cmd_ready), 32'd1);
    cmd_valid = 1'b1; cmd_addr = a; cmd_burst = br; cmd_size = sz;
    cmd_write = wr; cmd_len = ln; bus_ready = 1'b1; loc_busy = 1'b0; bus_err = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(bus_burst == br && bus_size == sz && bus_write == wr, "R3",
        {26'd0, bus_burst, bus_size}, {26'd0, br, sz});
    for (int c = 0; c < 200 && !seen_done; c++) begin
      if (c > 0) @(negedge clk);
      if (prd) begin
        chk(rd_valid && rd_data == rpat(ridx), "R10", rd_data, rpat(ridx));
        prd = 0;
      end
      if (hold) begin
        chk(bus_addr == ha && bus_trans == ht, "R7", bus_addr, ha);
        hold = 0;
      end
      if (done) begin
        seen_done = 1;
        chk(err_flag == (err_beat >= 0), "R11", 32'(err_flag), 32'(err_beat >= 0));
        chk(bus_trans == TR_IDLE, err_beat >= 0 ? "R11" : "R12", 32'(bus_trans), 32'(TR_IDLE));
      end else begin
        if (pv && wr) chk(bus_wdata == wpat(pidx), "R9", bus_wdata, wpat(pidx));
        bus_ready = (c < 32) ? !stall[c] : 1'b1;
        loc_busy  = (c < 32) ? busy[c] : 1'b0;
        bus_err   = pv && (pidx == err_beat);
        bus_rdata = rpat(pidx);
        wr_data   = wpat(acc);
        hold = !bus_ready && bus_trans[1];
        ha   = bus_addr;
        ht   = bus_trans;
        if (bus_ready) begin
          bit eh;
          eh = 0;
          if (pv) begin
            if (bus_err) eh = 1;
            else if (!wr) begin prd = 1; ridx = pidx; end
            pv = 0;
          end
          if (bus_trans == TR_BUSY) begin
            busy_seen++;
            chk(bus_addr == ea, "R8", bus_addr, ea);
          end
          if (bus_trans[1]) begin
            chk(bus_trans == (acc == 0 ? TR_NSEQ : TR_SEQ), acc == 0 ? "R3" : "R4",
                32'(bus_trans), 32'(acc == 0 ? TR_NSEQ : TR_SEQ));
            chk(bus_addr == ea, is_wrap(br) ? "R5" : "R4", bus_addr, ea);
            pv   = !eh;
            pidx = acc;
            acc++;
            ea = enext(ea, sz, br, beats);
          end
        end
      end
    end
    bus_err = 1'b0; bus_ready = 1'b1; loc_busy = 1'b0;
    chk(seen_done, "R12", 32'(seen_done), 32'd1);
    chk(acc == exp_cnt, "R6", 32'(acc), 32'(exp_cnt));
    if (busy != 0) chk(busy_seen > 0, "R8", 32'(busy_seen), 32'd1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(bus_trans == TR_IDLE, "R1", 32'(bus_trans), 32'(TR_IDLE));
    chk(cmd_ready == 1'b1, "R1", 32'(cmd_ready), 32'd1);
    chk(done == 1'b0 && rd_valid == 1'b0, "R1", {30'd0, done, rd_valid}, 32'd0);
  endtask

  task automatic t_reject;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = 32'h0000_4000; cmd_burst = BR_INCR4; cmd_size = 3'd3;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(cmd_reject == 1'b1, "R2", 32'(cmd_reject), 32'd1);
    chk(bus_trans == TR_IDLE, "R2", 32'(bus_trans), 32'(TR_IDLE));
    @(negedge clk);
    chk(cmd_reject == 1'b0 && bus_trans == TR_IDLE, "R2", {29'd0, cmd_reject, bus_trans}, 32'd0);
  endtask

  task automatic t_incr4_read;   run_burst(32'h0000_1000, BR_INCR4, 3'd2, 1'b0, 8'd0, 32'h0, 32'h0, -1); endtask
  task automatic t_wrap8_write;  run_burst(32'h0000_1006, BR_WRAP8, 3'd1, 1'b1, 8'd0, 32'h0, 32'h0, -1); endtask
  task automatic t_wrap4_wait;   run_burst(32'h0000_2008, BR_WRAP4, 3'd2, 1'b0, 8'd0, 32'h66, 32'h0, -1); endtask
  task automatic t_undef_busy;   run_burst(32'h0000_0031, BR_INCR, 3'd0, 1'b1, 8'd5, 32'h100, 32'h4C, -1); endtask
  task automatic t_single;       run_burst(32'h0000_0200, BR_SINGLE, 3'd2, 1'b1, 8'd0, 32'h0, 32'h0, -1); endtask
  task automatic t_wrap16_byte;  run_burst(32'h0000_300D, BR_WRAP16, 3'd0, 1'b0, 8'd0, 32'h0, 32'h0, -1); endtask
  task automatic t_incr8_half;   run_burst(32'h0000_0F0A, BR_INCR8, 3'd1, 1'b0, 8'd0, 32'h14, 32'h0, -1); endtask
  task automatic t_incr16_err;   run_burst(32'h0000_5000, BR_INCR16, 3'd2, 1'b0, 8'd0, 32'h0, 32'h0, 3); endtask
  task automatic t_write_err;    run_burst(32'h0000_6010, BR_WRAP4, 3'd2, 1'b1, 8'd0, 32'h0, 32'h0, 0); endtask

  task automatic finish_up;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog act=0 exp=1");
    finish_up();
  end

  initial begin
    rst = 1'b1; cmd_valid = 1'b0; cmd_addr = '0; cmd_burst = '0; cmd_size = '0;
    cmd_write = 1'b0; cmd_len = '0; loc_busy = 1'b0; wr_data = '0;
    bus_ready = 1'b1; bus_err = 1'b0; bus_rdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_reject();
    t_incr4_read();
    t_wrap8_write();
    t_wrap4_wait();
    t_undef_busy();
    t_single();
    t_wrap16_byte();
    t_incr8_half();
    t_incr16_err();
    t_write_err();
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule